// File: doc/BRIEF.md
# SATA Link Bring-up Sequencer

This block runs the link-establishment loop for one SATA port. After a start pulse it reads the controller's version register over a simple bus-master port. If the version matches the expected value, each attempt begins with a PHY reset: an override-disable command to an external override sequencer, an assert write and then a release write to the port control register with a one-millisecond gap after each, and an override-apply command. The block then polls the detection field of the port status register once per millisecond over a bounded window.

A detection code of 3 ends the run with success. If the window runs out while a device is still reported present (nonzero detection), the attempt restarts from iteration 0, up to a parameterised number of restarts. A zero code at the end of the window, or an exhausted restart budget, ends the run with failure. Timing comes from an external one-cycle millisecond tick. The register file, the PHY and the override sequencer sit outside this block.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, busReq, ovrOffReq, ovrOnReq, done and linkFail are all 0.
- R2: A start pulse in the idle state first issues a bus read of VER_ADDR (default 0xF8). No other request comes before it.
- R3: If the version word equals VER_MATCH (0x3332302A), iteration 0 of every attempt performs these steps in order: an override-off handshake; a write of 0x301 to CTRL_ADDR; a wait for the next msTick; a write of 0x300 to CTRL_ADDR; a wait for the next msTick; an override-on handshake. Only then comes the status read. Bus writes carry only those two values to that address.
- R4: If the version word differs from VER_MATCH, the run issues no override handshakes and no bus writes, only status reads.
- R5: Every iteration reads STAT_ADDR. If bits [3:0] of the returned word equal 3, the run ends with done and linkFail=0, and no further request is issued.
- R6: After a status read that does not show link-up, the next status read within the same attempt follows exactly one msTick later. A window holds POLL_WINDOW (default 4) status reads.
- R7: When a window ends and the last detection code is nonzero, a new attempt starts at iteration 0, including the reset steps of R3 when the version matched. At most MAX_RETRY (default 3) such restarts occur per run.
- R8: When a window ends with a zero detection code, or with a nonzero code after MAX_RETRY restarts, the run ends with done and linkFail=1.
- R9: done is high for exactly one cycle per run. A start pulse while a run is in progress has no effect.
- R10: At most one of busReq, ovrOffReq and ovrOnReq is high at a time. A bus request holds its address, write flag and write data stable until busAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| start | input | 1 | Begins a run when idle |
| busReq | output | 1 | Bus request, held until busAck |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Register address |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Completes the pending bus request |
| busRdata | input | DATA_W | Read data, valid with busAck |
| ovrOffReq | output | 1 | Override-disable command, held until ovrAck |
| ovrOnReq | output | 1 | Override-apply command, held until ovrAck |
| ovrAck | input | 1 | Completes the pending override command |
| done | output | 1 | One-cycle end-of-run pulse |
| linkFail | output | 1 | Result of the last run: 0 link up, 1 failure |

## Verification
Any corruption of the iteration or restart counters shows at the bus port within one polling window. The number of status reads between reset pulses changes, and the final linkFail value changes with it. A wrong version flag shows up immediately after the version read, as reset writes that should not be there or that are missing. A timing fault shows within the same millisecond: a skipped or doubled tick wait changes the tick count between the two control writes or between consecutive status reads. The bench therefore compares the full ordered event trace of each run, and the tick spacing inside it, against a transaction-level model.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

  localparam int DET_W = 4;
  localparam logic [DET_W-1:0] DET_LINK_UP = 4'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_VER_RD, S_ITER, S_OVR_OFF, S_RST_ON, S_GAP1,
    S_RST_OFF, S_GAP2, S_OVR_ON, S_STS_RD, S_POLL_GAP
  } seqState_t;

  typedef enum logic [1:0] {OP_VER, OP_RST_ON, OP_RST_OFF, OP_STS} busOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRun;
    logic loadVer;
    logic loadDet;
    logic incIter;
    logic restart;
    logic finishOk;
    logic finishFail;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic verMatch;
    logic iterZero;
    logic lastIter;
    logic linkUpNow;
    logic detNonzero;
    logic retryLeft;
  } dpFlags_t;

endpackage

// File: rtl/link_bringup_ctl.sv
module link_bringup_ctl
  import link_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       msTick,
  input  logic       busAck,
  input  logic       ovrAck,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       busReq,
  output busOp_t     busOp,
  output logic       ovrOffReq,
  output logic       ovrOnReq
);

  seqState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState  = state;
    strobe    = '0;
    busReq    = 1'b0;
    busOp     = OP_VER;
    ovrOffReq = 1'b0;
    ovrOnReq  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.clrRun = 1'b1;
          nxtState      = S_VER_RD;
        end
      end
      S_VER_RD: begin
        busReq = 1'b1;
        busOp  = OP_VER;
        if (busAck) begin
          strobe.loadVer = 1'b1;
          nxtState       = S_ITER;
        end
      end
      S_ITER: begin
        if (flags.iterZero && flags.verMatch) nxtState = S_OVR_OFF;
        else                                  nxtState = S_STS_RD;
      end
      S_OVR_OFF: begin
        ovrOffReq = 1'b1;
        if (ovrAck) nxtState = S_RST_ON;
      end
      S_RST_ON: begin
        busReq = 1'b1;
        busOp  = OP_RST_ON;
        if (busAck) nxtState = S_GAP1;
      end
      S_GAP1: begin
        if (msTick) nxtState = S_RST_OFF;
      end
      S_RST_OFF: begin
        busReq = 1'b1;
        busOp  = OP_RST_OFF;
        if (busAck) nxtState = S_GAP2;
      end
      S_GAP2: begin
        if (msTick) nxtState = S_OVR_ON;
      end
      S_OVR_ON: begin
        ovrOnReq = 1'b1;
        if (ovrAck) nxtState = S_STS_RD;
      end
      S_STS_RD: begin
        busReq = 1'b1;
        busOp  = OP_STS;
        if (busAck) begin
          if (flags.linkUpNow) begin
            strobe.finishOk = 1'b1;
            nxtState        = S_IDLE;
          end else begin
            strobe.loadDet = 1'b1;
            nxtState       = S_POLL_GAP;
          end
        end
      end
      S_POLL_GAP: begin
        if (msTick) begin
          if (!flags.lastIter) begin
            strobe.incIter = 1'b1;
            nxtState       = S_ITER;
          end else if (flags.detNonzero && flags.retryLeft) begin
            strobe.restart = 1'b1;
            nxtState       = S_ITER;
          end else begin
            strobe.finishFail = 1'b1;
            nxtState          = S_IDLE;
          end
        end
      end
      default: nxtState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/link_bringup_dp.sv
module link_bringup_dp
  import link_bringup_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] VER_ADDR    = 32'h0000_00F8,
  parameter logic [31:0] CTRL_ADDR   = 32'h0000_012C,
  parameter logic [31:0] STAT_ADDR   = 32'h0000_0128,
  parameter logic [31:0] VER_MATCH   = 32'h3332_302A,
  parameter logic [31:0] RST_ON_VAL  = 32'h0000_0301,
  parameter logic [31:0] RST_OFF_VAL = 32'h0000_0300,
  parameter int          POLL_WINDOW = 4,
  parameter int          MAX_RETRY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  busOp_t            busOp,
  input  logic [DATA_W-1:0] busRdata,
  output dpFlags_t          flags,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              done,
  output logic              linkFail
);

  localparam int ITER_W  = $clog2(POLL_WINDOW + 1);
  localparam int RETRY_W = $clog2(MAX_RETRY + 2);
  localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(POLL_WINDOW - 1);

  logic [ITER_W-1:0]  iterCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic               verMatchQ;
  logic [DET_W-1:0]   lastDet;
  logic               retryLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iterCnt   <= '0;
      retryCnt  <= '0;
      verMatchQ <= 1'b0;
      lastDet   <= '0;
      done      <= 1'b0;
      linkFail  <= 1'b0;
    end else begin
      done <= strobe.finishOk | strobe.finishFail;
      if (strobe.clrRun) begin
        iterCnt  <= '0;
        retryCnt <= '0;
      end
      if (strobe.loadVer) verMatchQ <= (busRdata == DATA_W'(VER_MATCH));
      if (strobe.loadDet) lastDet <= busRdata[DET_W-1:0];
      if (strobe.incIter) iterCnt <= iterCnt + 1'b1;
      if (strobe.restart) begin
        iterCnt  <= '0;
        retryCnt <= retryCnt + 1'b1;
      end
      if (strobe.finishOk)   linkFail <= 1'b0;
      if (strobe.finishFail) linkFail <= 1'b1;
    end
  end

  generate
    if (MAX_RETRY == 0) begin : gNoRetry
      assign retryLeft = 1'b0;
    end else begin : gRetry
      assign retryLeft = (retryCnt < RETRY_W'(MAX_RETRY));
    end
  endgenerate

  always_comb begin
    flags.verMatch   = verMatchQ;
    flags.iterZero   = (iterCnt == '0);
    flags.lastIter   = (iterCnt == ITER_LAST);
    flags.linkUpNow  = (busRdata[DET_W-1:0] == DET_LINK_UP);
    flags.detNonzero = (lastDet != '0);
    flags.retryLeft  = retryLeft;
  end

  always_comb begin
    busWe    = 1'b0;
    busAddr  = ADDR_W'(VER_ADDR);
    busWdata = '0;
    unique case (busOp)
      OP_VER: busAddr = ADDR_W'(VER_ADDR);
      OP_RST_ON: begin
        busWe    = 1'b1;
        busAddr  = ADDR_W'(CTRL_ADDR);
        busWdata = DATA_W'(RST_ON_VAL);
      end
      OP_RST_OFF: begin
        busWe    = 1'b1;
        busAddr  = ADDR_W'(CTRL_ADDR);
        busWdata = DATA_W'(RST_OFF_VAL);
      end
      OP_STS: busAddr = ADDR_W'(STAT_ADDR);
      default: busAddr = ADDR_W'(VER_ADDR);
    endcase
  end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import link_bringup_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] VER_ADDR    = 32'h0000_00F8,
  parameter logic [31:0] CTRL_ADDR   = 32'h0000_012C,
  parameter logic [31:0] STAT_ADDR   = 32'h0000_0128,
  parameter logic [31:0] VER_MATCH   = 32'h3332_302A,
  parameter logic [31:0] RST_ON_VAL  = 32'h0000_0301,
  parameter logic [31:0] RST_OFF_VAL = 32'h0000_0300,
  parameter int          POLL_WINDOW = 4,
  parameter int          MAX_RETRY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              start,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  output logic              ovrOffReq,
  output logic              ovrOnReq,
  input  logic              ovrAck,
  output logic              done,
  output logic              linkFail
);

  ctlStrobe_t strobe;
  dpFlags_t   flags;
  busOp_t     busOp;

  link_bringup_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .msTick    (msTick),
    .busAck    (busAck),
    .ovrAck    (ovrAck),
    .flags     (flags),
    .strobe    (strobe),
    .busReq    (busReq),
    .busOp     (busOp),
    .ovrOffReq (ovrOffReq),
    .ovrOnReq  (ovrOnReq)
  );

  link_bringup_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .VER_ADDR    (VER_ADDR),
    .CTRL_ADDR   (CTRL_ADDR),
    .STAT_ADDR   (STAT_ADDR),
    .VER_MATCH   (VER_MATCH),
    .RST_ON_VAL  (RST_ON_VAL),
    .RST_OFF_VAL (RST_OFF_VAL),
    .POLL_WINDOW (POLL_WINDOW),
    .MAX_RETRY   (MAX_RETRY)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busOp    (busOp),
    .busRdata (busRdata),
    .flags    (flags),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .done     (done),
    .linkFail (linkFail)
  );

endmodule

// File: rtl/link_bringup_chk.sv
module link_bringup_chk #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] CTRL_ADDR   = 32'h0000_012C,
  parameter logic [31:0] RST_ON_VAL  = 32'h0000_0301,
  parameter logic [31:0] RST_OFF_VAL = 32'h0000_0300
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busAck,
  input logic              ovrOffReq,
  input logic              ovrOnReq,
  input logic              ovrAck,
  input logic              done
);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)); // R10

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busReq, ovrOffReq, ovrOnReq})); // R10

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovrOffReq || ovrOnReq) && !ovrAck |=> $stable(ovrOffReq) && $stable(ovrOnReq)); // R3

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWe |-> busAddr == ADDR_W'(CTRL_ADDR) &&
      (busWdata == DATA_W'(RST_ON_VAL) || busWdata == DATA_W'(RST_OFF_VAL))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq && !ovrOffReq && !ovrOnReq); // R5

endmodule

bind link_bringup_seq link_bringup_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CTRL_ADDR   (CTRL_ADDR),
  .RST_ON_VAL  (RST_ON_VAL),
  .RST_OFF_VAL (RST_OFF_VAL)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busAck    (busAck),
  .ovrOffReq (ovrOffReq),
  .ovrOnReq  (ovrOnReq),
  .ovrAck    (ovrAck),
  .done      (done)
);

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;

  localparam int W  = 4;
  localparam int MR = 3;
  localparam int TICK_PER = 40;
  localparam logic [31:0] VADDR = 32'h0000_00F8;
  localparam logic [31:0] CADDR = 32'h0000_012C;
  localparam logic [31:0] SADDR = 32'h0000_0128;
  localparam logic [31:0] VGOOD = 32'h3332_302A;

  // event codes: 1 version read, 2 override off, 3 assert write,
  // 4 release write, 5 override on, 6 status read, 9 unexpected access
  logic clk = 0, rstN = 0, msTick = 0, start = 0;
  logic busReq, busWe, busAck = 0, ovrOffReq, ovrOnReq, ovrAck = 0, done, linkFail;
  logic [31:0] busAddr, busWdata, busRdata = '0;

  int nChk = 0, nFail = 0, cycles = 0;
  int evLog [64];
  int expEv [64];
  int evN, expN, expFail, prevEv, tickSince, tickDiv = 0;
  int detSeq [64];
  int stsIdx, doneCycles = 0, lastFail = 0;
  logic [31:0] verVal = 32'h3332_302A;
  logic busPend = 0, ovrPend = 0, ovrKindOn = 0;
  int busWait = 0, ovrWait = 0;
  logic [31:0] capAddr, capWd;
  logic capWe;
  logic finished = 0;

  always #2.5 clk = ~clk;

  link_bringup_seq #(.POLL_WINDOW(W), .MAX_RETRY(MR)) u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .start(start),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .ovrOffReq(ovrOffReq),
    .ovrOnReq(ovrOnReq), .ovrAck(ovrAck), .done(done), .linkFail(linkFail));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic logEv(input int code);
    if (code == 6 && prevEv == 6) chk(tickSince == 1, "R6 tick gap between polls", tickSince, 1);
    if (code == 4) chk(tickSince == 1, "R3 tick gap assert to release", tickSince, 1);
    if (code == 5) chk(tickSince == 1, "R3 tick gap release to override-on", tickSince, 1);
    if (code == 3 || code == 4 || code == 6) tickSince = 0;
    if (evN < 64) evLog[evN] = code;
    evN++;
    prevEv = code;
  endtask

  // all negedge-side activity in one process
  always @(negedge clk) begin
    cycles++;
    if (msTick) tickSince++;
    tickDiv = (tickDiv == TICK_PER - 1) ? 0 : tickDiv + 1;
    msTick = (tickDiv == 0);
    if (done) begin
      doneCycles++;
      lastFail = int'(linkFail);
    end
    // bus slave
    if (busAck) begin
      busAck = 0;
      if (!capWe && capAddr == VADDR)                       logEv(1);
      else if (capWe && capAddr == CADDR && capWd == 32'h301) logEv(3);
      else if (capWe && capAddr == CADDR && capWd == 32'h300) logEv(4);
      else if (!capWe && capAddr == SADDR)                  logEv(6);
      else                                                  logEv(9);
    end else if (busReq) begin
      if (!busPend) begin
        busPend = 1; busWait = $urandom % 4;
        capAddr = busAddr; capWe = busWe; capWd = busWdata;
      end
      if (busWait == 0) begin
        chk(busAddr == capAddr && busWe == capWe && busWdata == capWd,
            "R10 request stable until ack", longint'(busAddr), longint'(capAddr));
        busPend = 0; busAck = 1;
        if (capAddr == VADDR) busRdata = verVal;
        else if (capAddr == SADDR) begin
          busRdata = {$urandom % 32'h1000_0000, 4'(detSeq[stsIdx])};
          if (stsIdx < 63) stsIdx++;
        end else busRdata = $urandom;
      end else busWait--;
    end
    // override sequencer
    if (ovrAck) begin
      ovrAck = 0;
      logEv(ovrKindOn ? 5 : 2);
    end else if (ovrOffReq || ovrOnReq) begin
      if (!ovrPend) begin
        ovrPend = 1; ovrWait = $urandom % 4; ovrKindOn = ovrOnReq;
      end
      if (ovrWait == 0) begin ovrPend = 0; ovrAck = 1; end
      else ovrWait--;
    end
    if (cycles > 190000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  task automatic push(input int c);
    if (expN < 64) expEv[expN] = c;
    expN++;
  endtask

  // transaction-level expectation of one run
  task automatic refModel(input bit m);
    int k = 0, it = 0, rt = 0, d;
    bit fin = 0;
    expN = 0;
    push(1);
    while (!fin) begin
      if (it == 0 && m) begin push(2); push(3); push(4); push(5); end
      push(6);
      d = detSeq[k]; k++;
      if (d == 3) begin expFail = 0; fin = 1; end
      else begin
        it++;
        if (it == W) begin
          if (d != 0 && rt < MR) begin it = 0; rt++; end
          else begin expFail = 1; fin = 1; end
        end
      end
    end
  endtask

  task automatic runScen(input bit m, input bit poke);
    int d0, wt;
    verVal = m ? VGOOD : (VGOOD ^ (32'h1 << ($urandom % 32)));
    evN = 0; stsIdx = 0; prevEv = 0;
    refModel(m);
    d0 = doneCycles;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    wt = 0;
    while (doneCycles == d0 && wt < 20000) begin @(posedge clk); wt++; end
    repeat (6) @(posedge clk);
    chk(wt < 20000, "R9 run completes", wt, 20000);
    chk(doneCycles - d0 == 1, "R9 single done cycle", doneCycles - d0, 1);
    chk(evN == expN, "R7 event count", evN, expN);
    chk(evN > 0 && evLog[0] == 1, "R2 version read first", evN > 0 ? evLog[0] : -1, 1);
    for (int i = 0; i < expN && i < evN && i < 64; i++)
      chk(evLog[i] == expEv[i], m ? "R3 event order" : "R4 event order", evLog[i], expEv[i]);
    chk(lastFail == expFail, expFail ? "R8 failure status" : "R5 success status", lastFail, expFail);
    chk(!busReq && !ovrOffReq && !ovrOnReq, "R5 quiet after end", busReq, 0);
  endtask

  task automatic fillDet(input int v);
    for (int i = 0; i < 64; i++) detSeq[i] = v;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    fillDet(0);
    repeat (5) @(negedge clk);
    chk(!busReq, "R1 busReq reset", busReq, 0);
    chk(!ovrOffReq && !ovrOnReq, "R1 override reqs reset", ovrOffReq | ovrOnReq, 0);
    chk(!done, "R1 done reset", done, 0);
    chk(!linkFail, "R1 linkFail reset", linkFail, 0);
    @(negedge clk) rstN = 1;
    repeat (3) @(negedge clk);
    chk(!busReq && !done, "R1 idle after reset", busReq, 0);

    fillDet(3); runScen(1, 0);                        // immediate link-up
    fillDet(0); runScen(1, 0);                        // R8 no device
    fillDet(1); runScen(1, 0);                        // R7 retries exhausted
    fillDet(1); detSeq[4] = 3; runScen(1, 0);         // restart then up
    fillDet(1); runScen(0, 0);                        // R4 mismatch, retries
    fillDet(0); detSeq[3] = 3; runScen(0, 0);         // up on last poll
    fillDet(1); detSeq[3] = 0; runScen(1, 0);         // zero at window end
    fillDet(1); runScen(1, 1);                        // R9 start while busy
    for (int s = 0; s < 20; s++) begin
      bit m;
      for (int i = 0; i < 64; i++) begin
        int r = $urandom % 16;
        detSeq[i] = (r < 3) ? 0 : (r < 13) ? 1 : (r < 14) ? 2 : 3;
      end
      m = ($urandom % 4) != 0;
      runScen(m, m && ($urandom % 3 == 0));
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule